// File: doc/BRIEF.md
# Multi-Flag Doorbell Mailbox

This block is a one-way signalling path between two agents. A sender agent and a receiver agent each own a small register port (write enable, read enable, address, write data, registered read data). The block holds a set of channels. Every channel carries a word of independent event flags. The sender raises any subset of flags with one write. Flags that are already raised stay raised, so several events can be pending on one channel at once, each on its own bit.

The receiver sees a level-sensitive interrupt per channel for as long as any flag it has not masked is raised. It reads the flag word, handles the events and writes ones to clear them. When a channel's word falls from non-zero to all-zero, the block records an acknowledge for that channel on the sender side. This acknowledge can raise a sender-side interrupt. Each side also has a combined interrupt that is the OR of its own unmasked per-channel interrupts.

Address layout on both ports: the low two bits select a register and the bits above them select the channel. The channel count is fixed by a parameter from 1 to 128, and the sender can read it back.

Top module: `doorbell_mbx`

## Requirements
- R1: After reset, every flag word, acknowledge bit and receiver mask is 0, every sender acknowledge enable is 1, and all interrupt outputs are low.
- R2: A sender write to register 1 (SET) of a channel ORs the data into that channel's flag word. Bits written as 0 stay as they were, and a read of SET returns 0.
- R3: A receiver write to register 1 (CLEAR) clears exactly the flag bits written as 1. Receiver register 0 and sender register 0 both return the flag word.
- R4: A channel's acknowledge bit (sender register 2, bit 0) is set in the cycle its flag word goes from non-zero to zero. It stays set until the sender writes 1 to that bit. Clearing an already-zero word sets nothing, and a new acknowledge event beats a clear in the same cycle.
- R5: The receiver interrupt of a channel is high while any flag is set whose bit in receiver register 2 (MASK, 1 = masked) is 0. Receiver register 3 (PENDING) returns the flags that are set and unmasked.
- R6: The sender interrupt of a channel is high while its acknowledge bit and its enable (sender register 3, bit 0) are both 1. Each side's combined interrupt is the OR of that side's per-channel interrupts.
- R7: Sender register 3 returns the channel count in bits [15:8]. Accesses to one channel never change another channel.
- R8: If a set and a clear hit the same bit of a channel in the same cycle, the bit ends up set.
- R9: Writes to a channel index at or above the channel count are ignored, and reads there return 0.
- R10: Read data appears with its valid strobe exactly one cycle after the read enable. It reflects the state before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_wr_en | input | 1 | Sender write strobe |
| s_rd_en | input | 1 | Sender read strobe |
| s_addr | input | CH_AW+2 | Sender address {channel, register} |
| s_wdata | input | FLAG_W | Sender write data |
| s_rdata | output | FLAG_W | Sender read data |
| s_rd_valid | output | 1 | Sender read data valid |
| r_wr_en | input | 1 | Receiver write strobe |
| r_rd_en | input | 1 | Receiver read strobe |
| r_addr | input | CH_AW+2 | Receiver address {channel, register} |
| r_wdata | input | FLAG_W | Receiver write data |
| r_rdata | output | FLAG_W | Receiver read data |
| r_rd_valid | output | 1 | Receiver read data valid |
| r_irq | output | NUM_CH | Per-channel receiver transfer interrupts |
| s_irq | output | NUM_CH | Per-channel sender acknowledge interrupts |
| r_comb_irq | output | 1 | Receiver combined interrupt |
| s_comb_irq | output | 1 | Sender combined interrupt |

## Verification
The flag word is the only state that both sides share. A wrong bit in it shows on the receiver interrupt in the cycle right after the faulty write, and on a register read one cycle after the read strobe. A missed or spurious acknowledge shows up on the sender interrupt in the same cycle as the flag word reaches zero. A decode slip between channels or registers shows up as a changed word on a neighbouring channel, which the next read of that channel reveals.

// File: rtl/db_pkg.sv
package db_pkg;
  typedef enum logic [1:0] {
    S_FLAGS = 2'd0,
    S_SET   = 2'd1,
    S_ACK   = 2'd2,
    S_CFG   = 2'd3
  } s_reg_e;

  typedef enum logic [1:0] {
    R_FLAGS = 2'd0,
    R_CLEAR = 2'd1,
    R_MASK  = 2'd2,
    R_PEND  = 2'd3
  } r_reg_e;

  localparam int CNT_LSB = 8;
  localparam int CNT_W   = 8;
endpackage

// File: rtl/db_addr_dec.sv
module db_addr_dec #(
  parameter int NUM_CH = 4,
  parameter int CH_AW  = 2
) (
  input  logic              wr_en,
  input  logic [CH_AW+1:0]  addr,
  output logic [1:0]        reg_sel,
  output logic [CH_AW-1:0]  ch_idx,
  output logic              in_range,
  output logic [NUM_CH-1:0] wr_hit
);
  always_comb begin
    reg_sel  = addr[1:0];
    ch_idx   = addr[CH_AW+1:2];
    in_range = ({1'b0, ch_idx} < (CH_AW+1)'(NUM_CH));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
    assign wr_hit[c] = wr_en && in_range && (ch_idx == CH_AW'(c));
  end
endmodule

// File: rtl/db_chan.sv
module db_chan #(
  parameter int FLAG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic [FLAG_W-1:0] set_val,
  input  logic              clr_we,
  input  logic [FLAG_W-1:0] clr_val,
  input  logic              mask_we,
  input  logic [FLAG_W-1:0] mask_val,
  input  logic              ack_clr,
  input  logic              ack_en_we,
  input  logic              ack_en_val,
  output logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] mask,
  output logic              ack,
  output logic              ack_en,
  output logic              rx_irq,
  output logic              tx_irq
);
  logic [FLAG_W-1:0] flag_q, flag_d;
  logic [FLAG_W-1:0] mask_q, mask_d;
  logic              ack_q, ack_d;
  logic              ack_en_q, ack_en_d;
  logic              flag_en, ack_upd;

  always_comb begin
    flag_en = set_we || clr_we;
    flag_d  = flag_q;
    if (clr_we) flag_d = flag_d & ~clr_val;
    if (set_we) flag_d = flag_d | set_val;

    ack_d = ack_q;
    if (ack_clr) ack_d = 1'b0;
    if ((flag_q != '0) && (flag_d == '0)) ack_d = 1'b1;
    ack_upd = ack_clr || flag_en;

    mask_d   = mask_we ? mask_val : mask_q;
    ack_en_d = ack_en_we ? ack_en_val : ack_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= '0;
      mask_q   <= '0;
      ack_q    <= 1'b0;
      ack_en_q <= 1'b1;
    end else begin
      if (flag_en)   flag_q   <= flag_d;
      if (mask_we)   mask_q   <= mask_d;
      if (ack_upd)   ack_q    <= ack_d;
      if (ack_en_we) ack_en_q <= ack_en_d;
    end
  end

  assign flags  = flag_q;
  assign mask   = mask_q;
  assign ack    = ack_q;
  assign ack_en = ack_en_q;
  assign rx_irq = |(flag_q & ~mask_q);
  assign tx_irq = ack_q & ack_en_q;

  // R2
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((flag_q & $past(set_val)) == $past(set_val)));

  // R3
  clr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((flag_q & $past(clr_val)) == '0));

  // R4
  ack_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flag_q) != '0) && (flag_q == '0)) |-> ack_q);

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_we || clr_we) |=> $stable(flag_q));
endmodule

// File: rtl/doorbell_mbx.sv
module doorbell_mbx
  import db_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int FLAG_W = 32,
  localparam int CH_AW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int AW    = CH_AW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_wr_en,
  input  logic              s_rd_en,
  input  logic [AW-1:0]     s_addr,
  input  logic [FLAG_W-1:0] s_wdata,
  output logic [FLAG_W-1:0] s_rdata,
  output logic              s_rd_valid,
  input  logic              r_wr_en,
  input  logic              r_rd_en,
  input  logic [AW-1:0]     r_addr,
  input  logic [FLAG_W-1:0] r_wdata,
  output logic [FLAG_W-1:0] r_rdata,
  output logic              r_rd_valid,
  output logic [NUM_CH-1:0] r_irq,
  output logic [NUM_CH-1:0] s_irq,
  output logic              r_comb_irq,
  output logic              s_comb_irq
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [1:0]        s_sel, r_sel;
  logic [CH_AW-1:0]  s_ch, r_ch;
  logic              s_ok, r_ok;
  logic [NUM_CH-1:0] s_hit, r_hit;

  db_addr_dec #(.NUM_CH(NUM_CH), .CH_AW(CH_AW)) s_dec_i (
    .wr_en(s_wr_en), .addr(s_addr), .reg_sel(s_sel), .ch_idx(s_ch),
    .in_range(s_ok), .wr_hit(s_hit));

  db_addr_dec #(.NUM_CH(NUM_CH), .CH_AW(CH_AW)) r_dec_i (
    .wr_en(r_wr_en), .addr(r_addr), .reg_sel(r_sel), .ch_idx(r_ch),
    .in_range(r_ok), .wr_hit(r_hit));

  logic [FLAG_W-1:0] flags_a [NUM_CH];
  logic [FLAG_W-1:0] mask_a  [NUM_CH];
  logic [NUM_CH-1:0] ack_a, ack_en_a;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    db_chan #(.FLAG_W(FLAG_W)) chan_i (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .set_we    (s_hit[c] && (s_sel == S_SET)),
      .set_val   (s_wdata),
      .clr_we    (r_hit[c] && (r_sel == R_CLEAR)),
      .clr_val   (r_wdata),
      .mask_we   (r_hit[c] && (r_sel == R_MASK)),
      .mask_val  (r_wdata),
      .ack_clr   (s_hit[c] && (s_sel == S_ACK) && s_wdata[0]),
      .ack_en_we (s_hit[c] && (s_sel == S_CFG)),
      .ack_en_val(s_wdata[0]),
      .flags     (flags_a[c]),
      .mask      (mask_a[c]),
      .ack       (ack_a[c]),
      .ack_en    (ack_en_a[c]),
      .rx_irq    (r_irq[c]),
      .tx_irq    (s_irq[c])
    );
  end

  assign r_comb_irq = |r_irq;
  assign s_comb_irq = |s_irq;

  localparam logic [FLAG_W-1:0] CNT_FIELD =
    FLAG_W'(CNT_W'(NUM_CH)) << CNT_LSB;

  logic [FLAG_W-1:0] s_rdata_d, r_rdata_d;
  logic [FLAG_W-1:0] s_rdata_q, r_rdata_q;
  logic              s_vld_q, r_vld_q;

  always_comb begin
    s_rdata_d = '0;
    if (s_ok) begin
      unique case (s_reg_e'(s_sel))
        S_FLAGS: s_rdata_d = flags_a[s_ch];
        S_SET:   s_rdata_d = '0;
        S_ACK:   s_rdata_d = FLAG_W'(ack_a[s_ch]);
        S_CFG:   s_rdata_d = CNT_FIELD | FLAG_W'(ack_en_a[s_ch]);
        default: s_rdata_d = '0;
      endcase
    end
  end

  always_comb begin
    r_rdata_d = '0;
    if (r_ok) begin
      unique case (r_reg_e'(r_sel))
        R_FLAGS: r_rdata_d = flags_a[r_ch];
        R_CLEAR: r_rdata_d = '0;
        R_MASK:  r_rdata_d = mask_a[r_ch];
        R_PEND:  r_rdata_d = flags_a[r_ch] & ~mask_a[r_ch];
        default: r_rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      s_rdata_q <= '0;
      r_rdata_q <= '0;
      s_vld_q   <= 1'b0;
      r_vld_q   <= 1'b0;
    end else begin
      s_vld_q <= s_rd_en;
      r_vld_q <= r_rd_en;
      if (s_rd_en) s_rdata_q <= s_rdata_d;
      if (r_rd_en) r_rdata_q <= r_rdata_d;
    end
  end

  assign s_rdata    = s_rdata_q;
  assign r_rdata    = r_rdata_q;
  assign s_rd_valid = s_vld_q;
  assign r_rd_valid = r_vld_q;

  // R10
  s_rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    s_rd_valid |-> $past(s_rd_en));

  // R10
  r_rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    r_rd_valid |-> $past(r_rd_en));
endmodule

// File: tb/doorbell_mbx_tb_top.sv
module doorbell_mbx_tb_top;
  localparam int  NCH = 3;
  localparam int  FW  = 32;
  localparam int  AW  = 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_wr_en = 0, s_rd_en = 0, r_wr_en = 0, r_rd_en = 0;
  logic [AW-1:0] s_addr = '0, r_addr = '0;
  logic [FW-1:0] s_wdata = '0, r_wdata = '0;
  logic [FW-1:0] s_rdata, r_rdata;
  logic s_rd_valid, r_rd_valid, r_comb_irq, s_comb_irq;
  logic [NCH-1:0] r_irq, s_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [FW-1:0] exp; string tag; } item_t;
  item_t s_q[$];
  item_t r_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  doorbell_mbx #(.NUM_CH(NCH), .FLAG_W(FW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_wr_en(s_wr_en), .s_rd_en(s_rd_en), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_rdata(s_rdata), .s_rd_valid(s_rd_valid),
    .r_wr_en(r_wr_en), .r_rd_en(r_rd_en), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_rd_valid(r_rd_valid),
    .r_irq(r_irq), .s_irq(s_irq), .r_comb_irq(r_comb_irq), .s_comb_irq(s_comb_irq));

  // monitor: pops expected read data as the design delivers it
  always @(negedge clk) begin
    if (rst_n && s_rd_valid) begin
      item_t it;
      checks++;
      if (s_q.size() == 0) begin
        errors++; $display("FAIL R10 sender: unexpected read data %h, expected none", s_rdata);
      end else begin
        it = s_q.pop_front();
        if (s_rdata !== it.exp) begin
          errors++; $display("FAIL %s sender read: got %h expected %h", it.tag, s_rdata, it.exp);
        end
      end
    end
    if (rst_n && r_rd_valid) begin
      item_t it;
      checks++;
      if (r_q.size() == 0) begin
        errors++; $display("FAIL R10 receiver: unexpected read data %h, expected none", r_rdata);
      end else begin
        it = r_q.pop_front();
        if (r_rdata !== it.exp) begin
          errors++; $display("FAIL %s receiver read: got %h expected %h", it.tag, r_rdata, it.exp);
        end
      end
    end
  end

  task automatic s_wr(input int ch, input int rg, input logic [FW-1:0] d);
    @(negedge clk);
    s_wr_en = 1; s_addr = AW'((ch << 2) | rg); s_wdata = d;
    @(negedge clk);
    s_wr_en = 0;
  endtask

  task automatic r_wr(input int ch, input int rg, input logic [FW-1:0] d);
    @(negedge clk);
    r_wr_en = 1; r_addr = AW'((ch << 2) | rg); r_wdata = d;
    @(negedge clk);
    r_wr_en = 0;
  endtask

  task automatic set_and_clr(input int ch, input logic [FW-1:0] sv, input logic [FW-1:0] cv);
    @(negedge clk);
    s_wr_en = 1; s_addr = AW'((ch << 2) | 1); s_wdata = sv;
    r_wr_en = 1; r_addr = AW'((ch << 2) | 1); r_wdata = cv;
    @(negedge clk);
    s_wr_en = 0; r_wr_en = 0;
  endtask

  task automatic s_rd(input int ch, input int rg, input logic [FW-1:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag; s_q.push_back(it);
    s_rd_en = 1; s_addr = AW'((ch << 2) | rg);
    @(negedge clk);
    s_rd_en = 0;
  endtask

  task automatic r_rd(input int ch, input int rg, input logic [FW-1:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag; r_q.push_back(it);
    r_rd_en = 1; r_addr = AW'((ch << 2) | rg);
    @(negedge clk);
    r_rd_en = 0;
  endtask

  task automatic chk_irq(input logic [NCH-1:0] er, input logic [NCH-1:0] es,
                         input string tag);
    checks++;
    if (r_irq !== er || s_irq !== es || r_comb_irq !== (|er) || s_comb_irq !== (|es)) begin
      errors++;
      $display("FAIL %s irq: r=%b s=%b rc=%b sc=%b expected r=%b s=%b rc=%b sc=%b",
               tag, r_irq, s_irq, r_comb_irq, s_comb_irq, er, es, |er, |es);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_irq('0, '0, "R1");
    s_rd(0, 3, 32'h0000_0301, "R1");   // ack enable 1, count 3 (R7)
    s_rd(2, 3, 32'h0000_0301, "R7");
    r_rd(1, 2, 32'h0, "R1");
    s_rd(1, 2, 32'h0, "R1");
    r_rd(2, 0, 32'h0, "R1");

    // R2 set ORs in
    s_wr(1, 1, 32'h0000_0005);
    chk_irq(3'b010, '0, "R2");
    r_rd(1, 0, 32'h0000_0005, "R2");
    s_wr(1, 1, 32'h0000_0100);
    s_wr(1, 1, 32'h0);
    r_rd(1, 0, 32'h0000_0105, "R2");
    s_rd(1, 0, 32'h0000_0105, "R3");
    s_rd(1, 1, 32'h0, "R2");

    // R5 masking
    r_wr(1, 2, 32'h0000_0105);
    chk_irq('0, '0, "R5");
    r_rd(1, 3, 32'h0, "R5");
    r_rd(1, 0, 32'h0000_0105, "R5");
    r_wr(1, 2, 32'h0000_0100);
    chk_irq(3'b010, '0, "R5");
    r_rd(1, 3, 32'h0000_0005, "R5");
    r_wr(1, 2, 32'h0);

    // R3 partial clear, no ack
    r_wr(1, 1, 32'h0000_0004);
    r_rd(1, 0, 32'h0000_0101, "R3");
    s_rd(1, 2, 32'h0, "R4");
    chk_irq(3'b010, '0, "R4");

    // R4 ack on empty
    r_wr(1, 1, 32'h0000_0101);
    chk_irq('0, 3'b010, "R4");
    s_rd(1, 2, 32'h1, "R4");

    // R6 ack enable and W1C
    s_wr(1, 3, 32'h0);
    chk_irq('0, '0, "R6");
    s_rd(1, 3, 32'h0000_0300, "R6");
    s_rd(1, 2, 32'h1, "R6");
    s_wr(1, 3, 32'h1);
    chk_irq('0, 3'b010, "R6");
    s_wr(1, 2, 32'h0);
    s_rd(1, 2, 32'h1, "R4");
    s_wr(1, 2, 32'h1);
    chk_irq('0, '0, "R4");
    s_rd(1, 2, 32'h0, "R4");

    // R8 simultaneous set and clear
    s_wr(0, 1, 32'h0000_000A);
    set_and_clr(0, 32'h0000_0002, 32'h0000_0002);
    r_rd(0, 0, 32'h0000_000A, "R8");
    set_and_clr(0, 32'h0000_0001, 32'h0000_0008);
    r_rd(0, 0, 32'h0000_0003, "R8");

    // R7 independence
    r_rd(2, 0, 32'h0, "R7");
    r_rd(1, 0, 32'h0, "R7");
    chk_irq(3'b001, '0, "R7");
    r_wr(0, 1, 32'h0000_0003);
    s_rd(0, 2, 32'h1, "R4");
    s_rd(2, 2, 32'h0, "R7");

    // R4 clearing an empty word gives no ack
    r_wr(2, 1, 32'hFFFF_FFFF);
    s_rd(2, 2, 32'h0, "R4");
    chk_irq('0, 3'b001, "R4");

    // R9 out-of-range channel
    s_wr(3, 1, 32'h0000_00FF);
    r_wr(3, 2, 32'hFFFF_FFFF);
    chk_irq('0, 3'b001, "R9");
    r_rd(3, 0, 32'h0, "R9");
    s_rd(3, 3, 32'h0, "R9");
    r_rd(3, 2, 32'h0, "R9");
    r_rd(0, 2, 32'h0, "R9");
    s_rd(2, 0, 32'h0, "R9");

    repeat (3) @(negedge clk);
    checks++;
    if (s_q.size() != 0 || r_q.size() != 0) begin
      errors++;
      $display("FAIL R10 pending reads: got %0d/%0d left expected 0/0", s_q.size(), r_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule